// File: doc/BRIEF.md
# MEI Snoop Coherence Controller

This block keeps the coherence state of every cache block in a small direct-mapped tag array. Each block is in one of three states: modified, exclusive or invalid. There is no shared state. The block watches snooped bus transactions. Each snoop carries a 32-bit physical address and a kind, which is either a read or an invalidate. A lookup of the tag and state decides the snoop status returned to the bus: no-hit, hit or address retry.

The cache side reports three local events: a fill, a write hit and a cast-out. These move a block between states. A snoop that finds a modified block cannot complete at once. The block answers with an address retry, raises a push request carrying the block's base address, and holds that request until a push-done handshake arrives. Only then does the block leave the modified state. It becomes invalid if the snoop was an invalidate and exclusive if it was a read. The push data path is outside this block.

Top module: `mei_snoop_ctl`

## Requirements
- R1: After reset every block is invalid, and `rsp_valid`, `push_req` and `inv_req` are low.
- R2: Each cycle with `snp_valid` high gives exactly one response, with `rsp_valid` high in the following cycle. Response codes are: 01 = no-hit, 10 = hit, 11 = retry. A snoop that misses the tag, or that finds an invalid block, answers 01 and changes no state.
- R3: Address bits 4..0 (the byte offset within a 32-byte block) take no part in matching. Bits 7..5 select the set and bits 31..8 form the tag.
- R4: A fill (`loc_op` = 01) writes the tag into the set and makes the block exclusive. A read snoop (`snp_kind` = 0) that finds an exclusive block answers 10 and leaves the block exclusive.
- R5: An invalidate snoop (`snp_kind` = 1) that finds an exclusive block answers 10 with no retry and makes the block invalid. `inv_req` pulses in the same cycle as that response.
- R6: A write hit (`loc_op` = 10) on an exclusive block makes it modified. A write whose tag misses changes nothing.
- R7: A cast-out (`loc_op` = 11) whose tag matches makes the block invalid.
- R8: A snoop that finds a modified block answers 11 when no push is pending. `push_req` then rises in the same cycle as the response. `push_addr` holds the block's base address (low 5 bits zero). Both stay unchanged until `push_done` is sampled.
- R9: While a push is pending, every snoop to the pending block answers 11. A snoop to a different modified block also answers 11 but starts no second push. A snoop to any other block is answered normally.
- R10: When `push_done` is sampled with a push pending, `push_req` is low in the next cycle. The block becomes exclusive after a read snoop. After an invalidate snoop it becomes invalid, and `inv_req` pulses in that next cycle.
- R11: A local event is ignored in a cycle with `snp_valid` high. A local event is also ignored when its set is that of a pending push.
- R12: `push_done` has no effect while no push is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | Snoop request present this cycle |
| snp_addr | input | 32 | Snooped physical address |
| snp_kind | input | 1 | 0 = read snoop, 1 = invalidate snoop |
| loc_valid | input | 1 | Local event present this cycle |
| loc_op | input | 2 | 01 fill, 10 write hit, 11 cast-out |
| loc_addr | input | 32 | Address of the local event |
| rsp_valid | output | 1 | Snoop response valid |
| rsp_code | output | 2 | 01 no-hit, 10 hit, 11 retry |
| push_req | output | 1 | Push of modified block requested |
| push_addr | output | 32 | Base address of the block to push |
| push_done | input | 1 | Push finished handshake |
| inv_req | output | 1 | One-cycle pulse: a block was invalidated by a snoop |

## Verification
A snoop response and any invalidate pulse it causes are due one cycle after the request. `push_req` rises together with the retry response. `push_req` falls, and a completion invalidate pulse appears, one cycle after `push_done` is sampled. The driver changes inputs on the falling edge. It queues the expected code and pulse value when it raises the request. The monitor pops the queue on the next falling edge, where the registered response is stable. Push checks are made on that same edge, and completion checks on the falling edge after `push_done` is dropped.

// File: rtl/mei_pkg.sv
package mei_pkg;
  localparam int PADDR_W = 32;

  typedef enum logic [1:0] {ST_I = 2'b00, ST_E = 2'b01, ST_M = 2'b10} mei_st_e;
  typedef enum logic [1:0] {RSP_NONE = 2'b00, RSP_NOHIT = 2'b01, RSP_HIT = 2'b10, RSP_RETRY = 2'b11} rsp_e;
  typedef enum logic [1:0] {LOC_NOP = 2'b00, LOC_FILL = 2'b01, LOC_WRITE = 2'b10, LOC_CAST = 2'b11} loc_e;

  // set number of an address: drop the byte offset, keep iw bits
  function automatic logic [PADDR_W-1:0] addr_index(input logic [PADDR_W-1:0] a, input int ow, input int iw);
    return (a >> ow) & ((PADDR_W'(1) << iw) - PADDR_W'(1));
  endfunction

  // tag of an address: everything above offset and set bits
  function automatic logic [PADDR_W-1:0] addr_tag(input logic [PADDR_W-1:0] a, input int ow, input int iw);
    return a >> (ow + iw);
  endfunction
endpackage

// File: rtl/mei_tag_store.sv
module mei_tag_store import mei_pkg::*; #(
  parameter int SETS  = 8,
  parameter int TAG_W = 24,
  parameter int NWR   = 3,
  parameter int NRD   = 2,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NWR-1:0]              wr_en,
  input  logic [NWR-1:0][IDX_W-1:0]   wr_idx,
  input  logic [NWR-1:0]              wr_tag_en,
  input  logic [NWR-1:0][TAG_W-1:0]   wr_tag,
  input  logic [NWR-1:0][1:0]         wr_st,
  input  logic [NRD-1:0][IDX_W-1:0]   rd_idx,
  output logic [NRD-1:0][TAG_W-1:0]   rd_tag,
  output logic [NRD-1:0][1:0]         rd_st
);
  logic [TAG_W-1:0] tag_q [SETS];
  logic [1:0]       st_q  [SETS];

  // port 0 has the highest priority: it is written last
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        st_q[s]  <= ST_I;
        tag_q[s] <= '0;
      end
    end else begin
      for (int p = NWR - 1; p >= 0; p--) begin
        if (wr_en[p]) begin
          st_q[wr_idx[p]] <= wr_st[p];
          if (wr_tag_en[p]) tag_q[wr_idx[p]] <= wr_tag[p];
        end
      end
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_tag[g] = tag_q[rd_idx[g]];
    assign rd_st[g]  = st_q[rd_idx[g]];
  end
endmodule

// File: rtl/mei_snoop_engine.sv
module mei_snoop_engine import mei_pkg::*; #(
  parameter int IDX_W    = 3,
  parameter int TAG_W    = 24,
  parameter int OFFSET_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               snp_valid,
  input  logic               snp_inval,
  input  logic [IDX_W-1:0]   snp_idx,
  input  logic [TAG_W-1:0]   snp_tag,
  input  logic [TAG_W-1:0]   look_tag,
  input  logic [1:0]         look_st,
  input  logic               push_done,
  output logic               rsp_valid,
  output logic [1:0]         rsp_code,
  output logic               push_req,
  output logic [PADDR_W-1:0] push_addr,
  output logic               inv_req,
  output logic               pend_valid,
  output logic [IDX_W-1:0]   pend_idx,
  output logic               snp_hit,
  output logic               snp_hit_pend,
  output logic [1:0]         wr_en,
  output logic [1:0][IDX_W-1:0] wr_idx,
  output logic [1:0][1:0]    wr_st
);
  logic             pend_q, pend_inv_q;
  logic [IDX_W-1:0] pend_idx_q;
  logic [TAG_W-1:0] pend_tag_q;
  logic             rsp_valid_q, inv_q;
  rsp_e             rsp_q, rsp_d;
  logic             start_push, inval_excl, push_finish;

  assign snp_hit      = snp_valid && (look_tag == snp_tag) && (look_st != ST_I);
  assign snp_hit_pend = snp_valid && pend_q && (pend_idx_q == snp_idx) && (pend_tag_q == snp_tag);
  assign start_push   = snp_hit && !snp_hit_pend && (look_st == ST_M) && !pend_q;
  assign inval_excl   = snp_hit && (look_st == ST_E) && snp_inval;
  assign push_finish  = pend_q && push_done;

  always_comb begin
    if (!snp_valid)               rsp_d = RSP_NONE;
    else if (snp_hit_pend)        rsp_d = RSP_RETRY;
    else if (!snp_hit)            rsp_d = RSP_NOHIT;
    else if (look_st == ST_M)     rsp_d = RSP_RETRY;
    else                          rsp_d = RSP_HIT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_q       <= RSP_NONE;
      inv_q       <= 1'b0;
      pend_q      <= 1'b0;
      pend_inv_q  <= 1'b0;
      pend_idx_q  <= '0;
      pend_tag_q  <= '0;
    end else begin
      rsp_valid_q <= snp_valid;
      rsp_q       <= rsp_d;
      inv_q       <= inval_excl || (push_finish && pend_inv_q);
      if (push_finish) begin
        pend_q <= 1'b0;
      end else if (start_push) begin
        pend_q     <= 1'b1;
        pend_inv_q <= snp_inval;
        pend_idx_q <= snp_idx;
        pend_tag_q <= snp_tag;
      end
    end
  end

  // write port 0: push completion, port 1: exclusive block invalidated
  assign wr_en[0]  = push_finish;
  assign wr_idx[0] = pend_idx_q;
  assign wr_st[0]  = pend_inv_q ? ST_I : ST_E;
  assign wr_en[1]  = inval_excl;
  assign wr_idx[1] = snp_idx;
  assign wr_st[1]  = ST_I;

  assign rsp_valid  = rsp_valid_q;
  assign rsp_code   = rsp_q;
  assign inv_req    = inv_q;
  assign push_req   = pend_q;
  assign push_addr  = {pend_tag_q, pend_idx_q, {OFFSET_W{1'b0}}};
  assign pend_valid = pend_q;
  assign pend_idx   = pend_idx_q;
endmodule

// File: rtl/mei_local_update.sv
module mei_local_update import mei_pkg::*; #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 24
) (
  input  logic             loc_valid,
  input  logic [1:0]       loc_op,
  input  logic [IDX_W-1:0] loc_idx,
  input  logic [TAG_W-1:0] loc_tag,
  input  logic [TAG_W-1:0] look_tag,
  input  logic [1:0]       look_st,
  input  logic             snp_valid,
  input  logic             pend_valid,
  input  logic [IDX_W-1:0] pend_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             wr_tag_en,
  output logic [TAG_W-1:0] wr_tag,
  output logic [1:0]       wr_st
);
  logic blocked, match;

  assign blocked = snp_valid || (pend_valid && (pend_idx == loc_idx));
  assign match   = (look_tag == loc_tag) && (look_st != ST_I);

  always_comb begin
    wr_en     = 1'b0;
    wr_tag_en = 1'b0;
    wr_st     = ST_I;
    if (loc_valid && !blocked) begin
      unique case (loc_e'(loc_op))
        LOC_FILL:  begin wr_en = 1'b1; wr_tag_en = 1'b1; wr_st = ST_E; end
        LOC_WRITE: begin wr_en = match && (look_st == ST_E); wr_st = ST_M; end
        LOC_CAST:  begin wr_en = match; wr_st = ST_I; end
        default:   wr_en = 1'b0;
      endcase
    end
  end

  assign wr_idx = loc_idx;
  assign wr_tag = loc_tag;
endmodule

// File: rtl/mei_snoop_ctl.sv
module mei_snoop_ctl import mei_pkg::*; #(
  parameter int SETS     = 8,
  parameter int OFFSET_W = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        snp_valid,
  input  logic [31:0] snp_addr,
  input  logic        snp_kind,
  input  logic        loc_valid,
  input  logic [1:0]  loc_op,
  input  logic [31:0] loc_addr,
  output logic        rsp_valid,
  output logic [1:0]  rsp_code,
  output logic        push_req,
  output logic [31:0] push_addr,
  input  logic        push_done,
  output logic        inv_req
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = PADDR_W - OFFSET_W - IDX_W;
  localparam int NWR   = 3;
  localparam int NRD   = 2;

  logic [IDX_W-1:0] snp_idx, loc_idx, pend_idx;
  logic [TAG_W-1:0] snp_tag, loc_tag;
  logic             pend_valid, snp_hit, snp_hit_pend;

  logic [NWR-1:0]             wr_en, wr_tag_en;
  logic [NWR-1:0][IDX_W-1:0]  wr_idx;
  logic [NWR-1:0][TAG_W-1:0]  wr_tag;
  logic [NWR-1:0][1:0]        wr_st;
  logic [NRD-1:0][IDX_W-1:0]  rd_idx;
  logic [NRD-1:0][TAG_W-1:0]  rd_tag;
  logic [NRD-1:0][1:0]        rd_st;

  logic [1:0]            eng_en;
  logic [1:0][IDX_W-1:0] eng_idx;
  logic [1:0][1:0]       eng_st;

  assign snp_idx = IDX_W'(addr_index(snp_addr, OFFSET_W, IDX_W));
  assign snp_tag = TAG_W'(addr_tag(snp_addr, OFFSET_W, IDX_W));
  assign loc_idx = IDX_W'(addr_index(loc_addr, OFFSET_W, IDX_W));
  assign loc_tag = TAG_W'(addr_tag(loc_addr, OFFSET_W, IDX_W));

  assign rd_idx[0] = snp_idx;
  assign rd_idx[1] = loc_idx;

  for (genvar p = 0; p < 2; p++) begin : g_eng_wr
    assign wr_en[p]     = eng_en[p];
    assign wr_idx[p]    = eng_idx[p];
    assign wr_st[p]     = eng_st[p];
    assign wr_tag_en[p] = 1'b0;
    assign wr_tag[p]    = '0;
  end

  mei_tag_store #(.SETS(SETS), .TAG_W(TAG_W), .NWR(NWR), .NRD(NRD)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag_en(wr_tag_en), .wr_tag(wr_tag), .wr_st(wr_st),
    .rd_idx(rd_idx), .rd_tag(rd_tag), .rd_st(rd_st)
  );

  mei_snoop_engine #(.IDX_W(IDX_W), .TAG_W(TAG_W), .OFFSET_W(OFFSET_W)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_inval(snp_kind), .snp_idx(snp_idx), .snp_tag(snp_tag),
    .look_tag(rd_tag[0]), .look_st(rd_st[0]), .push_done(push_done),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .push_req(push_req), .push_addr(push_addr),
    .inv_req(inv_req), .pend_valid(pend_valid), .pend_idx(pend_idx),
    .snp_hit(snp_hit), .snp_hit_pend(snp_hit_pend),
    .wr_en(eng_en), .wr_idx(eng_idx), .wr_st(eng_st)
  );

  mei_local_update #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_local (
    .loc_valid(loc_valid), .loc_op(loc_op), .loc_idx(loc_idx), .loc_tag(loc_tag),
    .look_tag(rd_tag[1]), .look_st(rd_st[1]),
    .snp_valid(snp_valid), .pend_valid(pend_valid), .pend_idx(pend_idx),
    .wr_en(wr_en[2]), .wr_idx(wr_idx[2]), .wr_tag_en(wr_tag_en[2]), .wr_tag(wr_tag[2]), .wr_st(wr_st[2])
  );
endmodule

// File: rtl/mei_snoop_ctl_chk.sv
module mei_snoop_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        snp_valid,
  input logic        rsp_valid,
  input logic [1:0]  rsp_code,
  input logic        push_req,
  input logic [31:0] push_addr,
  input logic        push_done,
  input logic        inv_req,
  input logic        snp_hit_pend,
  input logic        snp_hit
);
  a_r2_rsp_next: assert property (@(posedge clk) disable iff (!rst_n) snp_valid |=> rsp_valid);
  a_r2_rsp_only: assert property (@(posedge clk) disable iff (!rst_n) !snp_valid |=> !rsp_valid);
  a_r2_rsp_code: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> rsp_code != 2'b00);
  a_r2_miss_nohit: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_hit) |=> rsp_code == 2'b01);
  a_r9_pend_retry: assert property (@(posedge clk) disable iff (!rst_n) snp_hit_pend |=> rsp_code == 2'b11);
  a_r8_push_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(push_req) |-> rsp_valid && rsp_code == 2'b11);
  a_r8_push_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !push_done) |=> push_req && $stable(push_addr));
  a_r8_push_align: assert property (@(posedge clk) disable iff (!rst_n) push_req |-> push_addr[4:0] == 5'd0);
  a_r10_push_drop: assert property (@(posedge clk) disable iff (!rst_n) (push_req && push_done) |=> !push_req);
  a_r12_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_req && !snp_valid) |=> !push_req);
  a_r5_inv_source: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req |-> (rsp_valid && rsp_code == 2'b10) || $past(push_req && push_done));
endmodule

bind mei_snoop_ctl mei_snoop_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
  .push_req(push_req), .push_addr(push_addr), .push_done(push_done), .inv_req(inv_req),
  .snp_hit_pend(snp_hit_pend), .snp_hit(snp_hit)
);

// File: tb/mei_snoop_ctl_bench.sv
`timescale 1ns/1ps
module mei_snoop_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        snp_valid = 1'b0, snp_kind = 1'b0, loc_valid = 1'b0, push_done = 1'b0;
  logic [31:0] snp_addr = '0, loc_addr = '0;
  logic [1:0]  loc_op = 2'b00;
  logic        rsp_valid, push_req, inv_req;
  logic [1:0]  rsp_code;
  logic [31:0] push_addr;

  localparam logic [1:0] NOHIT = 2'b01, HIT = 2'b10, RETRY = 2'b11;
  localparam logic [1:0] FILL = 2'b01, WRITE = 2'b10, CAST = 2'b11;

  typedef struct { logic [1:0] code; logic inv; string req; } exp_t;
  exp_t exp_q[$];
  int checks = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mei_snoop_ctl u_mei_snoop_ctl (
    .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_kind(snp_kind),
    .loc_valid(loc_valid), .loc_op(loc_op), .loc_addr(loc_addr),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .push_req(push_req), .push_addr(push_addr),
    .push_done(push_done), .inv_req(inv_req)
  );

  // address = tag * 256 + set * 32 + byte offset
  function automatic logic [31:0] mk(input int unsigned tag, input int unsigned set, input int unsigned off);
    return 32'(tag * 256 + set * 32 + off);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic snoop(input logic [31:0] a, input logic k, input logic [1:0] ec, input logic ei, input string req);
    @(negedge clk);
    snp_valid = 1'b1; snp_addr = a; snp_kind = k;
    exp_q.push_back('{ec, ei, req});
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic local_ev(input logic [1:0] op, input logic [31:0] a);
    @(negedge clk);
    loc_valid = 1'b1; loc_op = op; loc_addr = a;
    @(negedge clk);
    loc_valid = 1'b0;
  endtask

  task automatic finish_push(input logic exp_inv, input string req);
    @(negedge clk);
    push_done = 1'b1;
    @(negedge clk);
    push_done = 1'b0;
    chk({31'd0, push_req}, 32'd0, req);
    chk({31'd0, inv_req}, {31'd0, exp_inv}, req);
  endtask

  // monitor: one queued expectation per response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++; bad++;
        $display("FAIL R2 actual=unexpected response expected=none");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({30'd0, rsp_code}, {30'd0, e.code}, e.req);
        chk({31'd0, inv_req}, {31'd0, e.inv}, e.req);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [31:0] a, b, c, d;
    a = mk(32'h123, 1, 0);
    b = mk(32'h456, 2, 0);
    c = mk(32'h789, 3, 0);
    d = mk(32'hABC, 4, 0);
    repeat (3) @(negedge clk);
    chk({29'd0, rsp_valid, push_req, inv_req}, 32'd0, "R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk({29'd0, rsp_valid, push_req, inv_req}, 32'd0, "R1 after reset");

    snoop(a, 1'b0, NOHIT, 1'b0, "R1 R2 empty");
    local_ev(FILL, a);
    snoop(a | 32'h1F, 1'b0, HIT, 1'b0, "R3 R4 offset ignored");
    snoop(mk(32'h124, 1, 0), 1'b0, NOHIT, 1'b0, "R3 other tag");
    snoop(mk(32'h123, 2, 0), 1'b0, NOHIT, 1'b0, "R3 other set");
    snoop(a, 1'b0, HIT, 1'b0, "R4 stays exclusive");
    snoop(a, 1'b1, HIT, 1'b1, "R5 invalidate exclusive");
    snoop(a, 1'b0, NOHIT, 1'b0, "R5 R2 now invalid");

    // write hit to modified, read snoop pushes
    local_ev(FILL, a);
    local_ev(WRITE, a);
    local_ev(FILL, b);
    snoop(a | 32'h4, 1'b0, RETRY, 1'b0, "R6 R8 modified retry");
    chk({31'd0, push_req}, 32'd1, "R8 push raised");
    chk(push_addr, a, "R8 push address");
    snoop(a, 1'b1, RETRY, 1'b0, "R9 pending same block");
    snoop(b, 1'b0, HIT, 1'b0, "R9 other block normal");
    local_ev(CAST, a);
    chk({31'd0, push_req}, 32'd1, "R8 push held");
    finish_push(1'b0, "R10 read done");
    snoop(a, 1'b0, HIT, 1'b0, "R10 R11 exclusive after read push");

    // invalidate snoop on modified
    local_ev(WRITE, a);
    snoop(a, 1'b1, RETRY, 1'b0, "R8 invalidate retry");
    finish_push(1'b1, "R10 invalidate done");
    snoop(a, 1'b0, NOHIT, 1'b0, "R10 invalid after push");

    // write miss and cast-out
    local_ev(WRITE, c);
    snoop(c, 1'b0, NOHIT, 1'b0, "R6 write miss no effect");
    local_ev(FILL, c);
    local_ev(WRITE, mk(32'h78A, 3, 0));
    snoop(c, 1'b0, HIT, 1'b0, "R6 write other tag no effect");
    local_ev(CAST, c);
    snoop(c, 1'b0, NOHIT, 1'b0, "R7 cast-out");

    // local event with snoop in the same cycle
    @(negedge clk);
    snp_valid = 1'b1; snp_addr = d; snp_kind = 1'b0;
    loc_valid = 1'b1; loc_op = FILL; loc_addr = d;
    exp_q.push_back('{NOHIT, 1'b0, "R11 concurrent"});
    @(negedge clk);
    snp_valid = 1'b0; loc_valid = 1'b0;
    snoop(d, 1'b0, NOHIT, 1'b0, "R11 fill ignored");

    // second modified block while a push is pending
    local_ev(FILL, a);
    local_ev(WRITE, a);
    local_ev(WRITE, b);
    snoop(a, 1'b0, RETRY, 1'b0, "R8 first push");
    snoop(b, 1'b0, RETRY, 1'b0, "R9 second modified");
    chk(push_addr, a, "R9 no second push");
    finish_push(1'b0, "R10 first done");
    snoop(b, 1'b1, RETRY, 1'b0, "R8 second push");
    chk(push_addr, b, "R8 second address");
    finish_push(1'b1, "R10 second done");
    snoop(b, 1'b0, NOHIT, 1'b0, "R10 second invalid");

    // done with nothing pending
    finish_push(1'b0, "R12 stray done");
    snoop(a, 1'b0, HIT, 1'b0, "R12 state kept");

    repeat (3) @(negedge clk);
    chk(32'(exp_q.size()), 32'd0, "R2 all responses seen");
    summary();
  end
endmodule